// File: doc/BRIEF.md
# Iterative Integer Divider with Non-Trapping Exceptions

This block divides a 32-bit dividend by a divisor and returns the quotient, the remainder and three condition flags: zero, sign and overflow. A request carries the dividend, the divisor and a two-bit mode. The mode selects signed or unsigned arithmetic. It also selects whether the divisor is the full word or only its low half, which is zero- or sign-extended. The result is produced by a restoring shift-subtract loop that retires one quotient bit per clock. Signed operands are converted to magnitudes before the loop, and the signs are restored after it.

The two exceptional cases do not trap. A divisor that is zero after extension, or a signed division of the most negative value by minus one, raises the overflow flag. The division then completes as if the divisor were one. The caller always receives a defined result and can test the flag.

Requests enter through a valid/ready pair and results leave through another. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The block holds one operation at a time, so `in_ready` stays low from that edge until the result has been taken. A result is offered with `out_valid` and is taken on an edge where `out_ready` is also high. While `out_ready` is low the result waits indefinitely, and every result output holds its value.

Top module: `div_unit`

## Requirements
- R1: `in_ready` is high only when no operation is in progress and no result is pending. It is never high while `out_valid` is high. After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `out_valid` rises exactly WIDTH (32) clock edges after the edge that accepted the request.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the quotient, remainder and all three flags stay unchanged.
- R4: Mode 1 (unsigned word) returns the floor quotient and the remainder of the two unsigned 32-bit values, so that quotient*divisor + remainder = dividend and remainder < divisor.
- R5: Mode 0 (signed word) treats both operands as two's complement. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R6: Mode 2 (unsigned halfword) divides unsigned, using only the low 16 divisor bits zero-extended. The upper 16 divisor bits have no effect.
- R7: Mode 3 (signed halfword) divides signed, using the low 16 divisor bits sign-extended. The upper 16 divisor bits have no effect.
- R8: A divisor that is zero after extension, in any mode, sets `out_ovf`. The quotient equals the dividend and the remainder is 0.
- R9: In modes 0 and 3, dividend 0x80000000 with an extended divisor of 0xFFFFFFFF sets `out_ovf`. The quotient is 0x80000000 and the remainder is 0.
- R10: `out_zero` is 1 exactly when the returned quotient is zero.
- R11: `out_sign` equals bit 31 of the returned quotient. `out_ovf` is 0 whenever neither R8 nor R9 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 32 | Divisor, full word or low half depending on mode |
| in_mode | input | 2 | 0 signed word, 1 unsigned word, 2 unsigned halfword divisor, 3 signed halfword divisor |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | 32 | Quotient |
| out_remainder | output | 32 | Remainder |
| out_zero | output | 1 | Quotient is zero |
| out_sign | output | 1 | Bit 31 of quotient |
| out_ovf | output | 1 | Divide-by-zero or signed overflow was substituted |

## Verification
A wrong iteration count or a stuck sequencer shows up at the port in one of two ways. `out_valid` may rise on a cycle other than the thirty-second after acceptance. Or `in_ready` may never come back, and the watchdog then catches it. A corrupted remainder or quotient register, or a wrong borrow decision, appears only once the result is offered, as a quotient/remainder pair that violates the division identity for that request. A lost sign or overflow marker captured at acceptance also appears only when the result is offered, as a wrongly signed quotient or remainder or a wrong flag. Back-pressure faults show as a result that changes while it waits for `out_ready`, and they are visible on the cycle after the change.

// File: rtl/divq_pkg.sv
package divq_pkg;

  typedef enum logic [1:0] {
    DM_SWORD = 2'd0,
    DM_UWORD = 2'd1,
    DM_UHALF = 2'd2,
    DM_SHALF = 2'd3
  } div_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } div_state_e;

  function automatic logic mode_is_signed(input div_mode_e m);
    return (m == DM_SWORD) || (m == DM_SHALF);
  endfunction

endpackage

// File: rtl/div_prep.sv
// Operand conditioning: divisor extension, exception detection, magnitudes.
module div_prep
  import divq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] dvd_mag,
  output logic [WIDTH-1:0] dvs_mag,
  output logic             q_neg,
  output logic             r_neg,
  output logic             ovf
);
  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  div_mode_e        m;
  logic [WIDTH-1:0] ext_dvs;
  logic             sgn;
  logic             a_neg;
  logic             b_neg;

  always_comb begin
    m = div_mode_e'(mode);
    case (m)
      DM_UHALF: ext_dvs = {{(WIDTH-HALF){1'b0}}, divisor[HALF-1:0]};
      DM_SHALF: ext_dvs = {{(WIDTH-HALF){divisor[HALF-1]}}, divisor[HALF-1:0]};
      default:  ext_dvs = divisor;
    endcase
    sgn   = mode_is_signed(m);
    ovf   = (ext_dvs == '0) || (sgn && (dividend == MOST_NEG) && (&ext_dvs));
    a_neg = sgn && dividend[WIDTH-1];
    b_neg = sgn && ext_dvs[WIDTH-1] && !ovf;
    dvd_mag = a_neg ? (~dividend + ONE) : dividend;
    if (ovf)        dvs_mag = ONE;
    else if (b_neg) dvs_mag = ~ext_dvs + ONE;
    else            dvs_mag = ext_dvs;
    q_neg = a_neg ^ b_neg;
    r_neg = a_neg;
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract loop, one quotient bit per step.
module div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dvd,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem,
  output logic             last
);
  localparam int CW = $clog2(WIDTH);

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] acc_r;
  logic [WIDTH-1:0] dvs_q;
  logic [CW-1:0]    cnt;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;

  always_comb begin
    shifted = {acc_r, acc_q[WIDTH-1]};
    trial   = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      acc_r <= '0;
      dvs_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      acc_q <= dvd;
      acc_r <= '0;
      dvs_q <= dvs;
      cnt   <= '0;
    end else if (step) begin
      acc_r <= trial[WIDTH] ? shifted[WIDTH-1:0] : trial[WIDTH-1:0];
      acc_q <= {acc_q[WIDTH-2:0], ~trial[WIDTH]};
      cnt   <= cnt + 1'b1;
    end
  end

  assign quo  = acc_q;
  assign rem  = acc_r;
  assign last = (cnt == CW'(WIDTH - 1));
endmodule

// File: rtl/div_fix.sv
// Sign restoration and flag generation.
module div_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] q_mag,
  input  logic [WIDTH-1:0] r_mag,
  input  logic             q_neg,
  input  logic             r_neg,
  input  logic             ovf_in,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             zero,
  output logic             sign,
  output logic             ovf
);
  always_comb begin
    quotient  = q_neg ? (~q_mag + 1'b1) : q_mag;
    remainder = r_neg ? (~r_mag + 1'b1) : r_mag;
    zero      = (quotient == '0);
    sign      = quotient[WIDTH-1];
    ovf       = ovf_in;
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import divq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_dividend,
  input  logic [WIDTH-1:0] in_divisor,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_quotient,
  output logic [WIDTH-1:0] out_remainder,
  output logic             out_zero,
  output logic             out_sign,
  output logic             out_ovf
);
  div_state_e       state;
  logic             accept;
  logic [WIDTH-1:0] dvd_mag;
  logic [WIDTH-1:0] dvs_mag;
  logic             q_neg_c;
  logic             r_neg_c;
  logic             ovf_c;
  logic             q_neg_r;
  logic             r_neg_r;
  logic             ovf_r;
  logic [WIDTH-1:0] q_mag;
  logic [WIDTH-1:0] r_mag;
  logic             last;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_valid && in_ready;

  div_prep #(.WIDTH(WIDTH)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .mode     (in_mode),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .q_neg    (q_neg_c),
    .r_neg    (r_neg_c),
    .ovf      (ovf_c)
  );

  div_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (state == ST_RUN),
    .dvd   (dvd_mag),
    .dvs   (dvs_mag),
    .quo   (q_mag),
    .rem   (r_mag),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_neg_r <= 1'b0;
      r_neg_r <= 1'b0;
      ovf_r   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_RUN;
          q_neg_r <= q_neg_c;
          r_neg_r <= r_neg_c;
          ovf_r   <= ovf_c;
        end
        ST_RUN:  if (last) state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  div_fix #(.WIDTH(WIDTH)) u_fix (
    .q_mag     (q_mag),
    .r_mag     (r_mag),
    .q_neg     (q_neg_r),
    .r_neg     (r_neg_r),
    .ovf_in    (ovf_r),
    .quotient  (out_quotient),
    .remainder (out_remainder),
    .zero      (out_zero),
    .sign      (out_sign),
    .ovf       (out_ovf)
  );
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_dividend,
  input logic [WIDTH-1:0] in_divisor,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_quotient,
  input logic [WIDTH-1:0] out_remainder,
  input logic             out_zero,
  input logic             out_sign,
  input logic             out_ovf
);
  localparam int HALF = WIDTH / 2;
  localparam int LW   = $clog2(WIDTH) + 2;

  logic [LW-1:0]    lat_cnt;
  logic [WIDTH-1:0] cap_dvd;
  logic [WIDTH-1:0] cap_dvs;
  logic [1:0]       cap_mode;
  logic             cap_dz;
  logic [WIDTH-1:0] ext_c;

  always_comb begin
    case (in_mode)
      2'd2:    ext_c = {{(WIDTH-HALF){1'b0}}, in_divisor[HALF-1:0]};
      2'd3:    ext_c = {{(WIDTH-HALF){in_divisor[HALF-1]}}, in_divisor[HALF-1:0]};
      default: ext_c = in_divisor;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      cap_dvd  <= '0;
      cap_dvs  <= '0;
      cap_mode <= '0;
      cap_dz   <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_cnt  <= '0;
      cap_dvd  <= in_dividend;
      cap_dvs  <= ext_c;
      cap_mode <= in_mode;
      cap_dz   <= (ext_c == '0);
    end else if (!out_valid && !in_ready) begin
      lat_cnt  <= lat_cnt + 1'b1;
    end
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == LW'(WIDTH)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) &&
      $stable(out_remainder) && $stable({out_zero, out_sign, out_ovf})));

  p_unsigned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_mode == 2'd1 && !cap_dz) |->
      ((({{WIDTH{1'b0}}, out_quotient} * {{WIDTH{1'b0}}, cap_dvs}) +
        {{WIDTH{1'b0}}, out_remainder}) == {{WIDTH{1'b0}}, cap_dvd}) &&
      (out_remainder < cap_dvs));

  p_rem_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (cap_mode == 2'd0 || cap_mode == 2'd3) && !out_ovf &&
     out_remainder != '0) |-> (out_remainder[WIDTH-1] == cap_dvd[WIDTH-1]));

  p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dz) |->
      (out_ovf && out_quotient == cap_dvd && out_remainder == '0));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dz) |-> (out_zero == (cap_dvd == '0)));

  p_sign_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dz) |-> (out_sign == cap_dvd[WIDTH-1]));
endmodule

bind div_unit div_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_dividend   (in_dividend),
  .in_divisor    (in_divisor),
  .in_mode       (in_mode),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder),
  .out_zero      (out_zero),
  .out_sign      (out_sign),
  .out_ovf       (out_ovf)
);

// File: tb/tb_div_unit.sv
module tb_div_unit;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         z;
    logic         s;
    logic         o;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic [1:0]   in_mode = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_quotient;
  logic [W-1:0] out_remainder;
  logic         out_zero;
  logic         out_sign;
  logic         out_ovf;

  int     n_checks = 0;
  int     n_fails  = 0;
  longint cyc      = 0;
  longint t_acc    = 0;
  bit     finished = 1'b0;
  exp_t   sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  div_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient), .out_remainder(out_remainder),
    .out_zero(out_zero), .out_sign(out_sign), .out_ovf(out_ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [1:0] m);
    exp_t e;
    logic [W-1:0] d;
    bit sg;
    longint sa, sd, q64, r64;
    d  = (m == 2'd2) ? {16'h0, b[15:0]} :
         (m == 2'd3) ? {{16{b[15]}}, b[15:0]} : b;
    sg = (m == 2'd0) || (m == 2'd3);
    e.tag = (m == 2'd0) ? "R5" : (m == 2'd1) ? "R4" : (m == 2'd2) ? "R6" : "R7";
    e.o = 1'b0;
    if (d == '0) begin
      e.o = 1'b1; e.q = a; e.r = '0; e.tag = "R8";
    end else if (sg && a == 32'h8000_0000 && d == 32'hFFFF_FFFF) begin
      e.o = 1'b1; e.q = a; e.r = '0; e.tag = "R9";
    end else if (sg) begin
      sa = longint'($signed(a));
      sd = longint'($signed(d));
      q64 = sa / sd;
      r64 = sa % sd;
      e.q = q64[W-1:0];
      e.r = r64[W-1:0];
    end else begin
      e.q = a / d;
      e.r = a % d;
    end
    e.z = (e.q == '0);
    e.s = e.q[W-1];
    return e;
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_dividend = a; in_divisor = b; in_mode = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    sb.push_back(model(a, b, m));
    @(negedge clk);
    t_acc = cyc;
    in_valid = 1'b0;
    in_dividend = $urandom;
    in_divisor  = $urandom;
  endtask

  // Back-pressure pattern, changed away from both edges.
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = ($urandom % 3) != 0;
    end
  end

  // Monitor / scoreboard.
  logic         prev_valid = 1'b0;
  logic         hold_pend  = 1'b0;
  logic [W-1:0] h_q, h_r;
  logic [2:0]   h_f;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend) begin
          check(out_valid && out_quotient == h_q && out_remainder == h_r &&
                {out_zero, out_sign, out_ovf} == h_f, "R3", "held result",
                out_quotient, h_q);
        end
        if (out_valid) begin
          check(!in_ready, "R1", "in_ready while result pending", {31'b0, in_ready}, '0);
          if (!prev_valid)
            check(cyc - t_acc == W, "R2", "latency", W'(cyc - t_acc), W'(W));
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R1", "unexpected result", out_quotient, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_quotient == e.q, e.tag, "quotient", out_quotient, e.q);
            check(out_remainder == e.r, e.tag, "remainder", out_remainder, e.r);
            check(out_zero == e.z, "R10", "zero flag", {31'b0, out_zero}, {31'b0, e.z});
            check(out_sign == e.s, "R11", "sign flag", {31'b0, out_sign}, {31'b0, e.s});
            check(out_ovf == e.o, e.o ? e.tag : "R11", "ovf flag",
                  {31'b0, out_ovf}, {31'b0, e.o});
          end
        end
        hold_pend = out_valid && !out_ready;
        h_q = out_quotient; h_r = out_remainder; h_f = {out_zero, out_sign, out_ovf};
        prev_valid = out_valid;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", {31'b0, in_ready}, 32'd1);
    check(out_valid == 1'b0, "R1", "valid after reset", {31'b0, out_valid}, 32'd0);

    // R4 unsigned word
    send(32'd100, 32'd7, 2'd1);
    send(32'hFFFF_FFFF, 32'd1, 2'd1);
    send(32'd5, 32'd10, 2'd1);               // R10 zero quotient
    send(32'hF000_0000, 32'd1, 2'd1);        // R11 sign bit
    send(32'hDEAD_BEEF, 32'hFFFF_FFFF, 2'd1);
    // R5 signed word
    send(-32'sd7, 32'd2, 2'd0);
    send(32'd7, -32'sd2, 2'd0);
    send(-32'sd7, -32'sd2, 2'd0);
    send(32'h8000_0000, 32'd1, 2'd0);
    send(32'h8000_0000, 32'd2, 2'd0);
    // R9 signed overflow
    send(32'h8000_0000, 32'hFFFF_FFFF, 2'd0);
    send(32'h8000_0000, 32'h1234_FFFF, 2'd3);
    // R8 zero divisor in every mode
    send(32'h1234_5678, 32'd0, 2'd0);
    send(32'h8765_4321, 32'd0, 2'd1);
    send(32'd0, 32'd0, 2'd1);
    send(32'hCAFE_0001, 32'hFFFF_0000, 2'd2);
    send(32'h8000_0000, 32'hABCD_0000, 2'd3);
    // R6 unsigned halfword, upper bits ignored
    send(32'd1000, 32'hABCD_0010, 2'd2);
    send(32'hFFFF_FFFF, 32'h0000_FFFF, 2'd2);
    // R7 signed halfword, upper bits ignored
    send(32'd100, 32'h0000_FFF6, 2'd3);
    send(-32'sd100, 32'h5555_0007, 2'd3);
    send(32'h7FFF_FFFF, 32'hFFFF_8000, 2'd3);

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 5 == 0) ? W'($urandom % 9) : $urandom;
      if (i % 7 == 0) b = b >> ($urandom % 30);
      send(a, b, 2'(i % 4));
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule